// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block caches recent virtual-to-physical page translations for a load/store unit. A request carries a 30-bit virtual page number, a 13-bit page offset, an 8-bit process identifier and an access type. All 32 entries are compared with the request at the same time. On a hit, the stored 21-bit frame number is placed above the unchanged offset to form a 34-bit physical address. Each entry keeps its own read and write permission bits, so a hit can still be refused for one kind of access.

The result is registered, so it appears on the response outputs in the clock cycle after the request. After a miss, page-walk logic outside this block installs the missing translation through the refill port. A single-cycle flush input invalidates every entry at once. Because each entry also holds a process identifier, the buffer does not have to be flushed on every context switch.

Top module: `xlat_buffer`

## Requirements
- R1: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. After reset every entry is invalid, so any lookup misses.
- R2: A lookup hits only if one entry is valid and holds both a tag equal to `req_vpn` and a process identifier equal to `req_pid`. The same page number under a different identifier misses.
- R3: The response address is `{frame, offset}`. Bits 12:0 always equal the request offset. Bits 33:13 hold the stored frame on a hit and are zero on a miss.
- R4: `req_store`=0 marks a load and `req_store`=1 marks a store. A hit raises `rsp_fault` when a load meets a cleared read bit or a store meets a cleared write bit. `rsp_fault` is never high without `rsp_hit`.
- R5: A refill whose page number and identifier already match a valid entry overwrites that entry in place.
- R6: If no entry matches, a refill goes to the lowest-numbered invalid entry.
- R7: If all entries are valid and none matches, a refill replaces the least recently used entry. An entry counts as used when it is refilled, or when a lookup hits it (hits that fault included).
- R8: A lookup in the same cycle as a refill sees the contents from before the refill. In that cycle only the refilled entry counts as used.
- R9: `flush` invalidates every entry at the next clock edge. A lookup in the same cycle as `flush` reports a miss. A refill in the same cycle is dropped, and no entry counts as used in that cycle.
- R10: All 32 entries can hold distinct translations at the same time, and each one hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | 30 | Virtual page number to translate |
| req_off | input | 13 | Page offset, passed through |
| req_pid | input | 8 | Process identifier of the request |
| req_store | input | 1 | 1 = store, 0 = load |
| fill_valid | input | 1 | Refill write strobe |
| fill_vpn | input | 30 | Page number of the new translation |
| fill_pid | input | 8 | Process identifier of the new translation |
| fill_pfn | input | 21 | Frame number of the new translation |
| fill_rd | input | 1 | Read permission of the new translation |
| fill_wr | input | 1 | Write permission of the new translation |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Permission refused on a hit |
| rsp_paddr | output | 34 | Physical address |

## Verification
Every lookup result is due exactly one clock after its request. Refill and flush change what the next cycle's lookup sees, and they change it after one edge. The reference model in the bench therefore computes each expected response from the entry state before the edge, and only then applies that cycle's refill, flush and recency update. It compares the registered outputs at the falling edge that follows. Replacement order cannot be observed directly, so it is checked through later lookups: the entry the model predicts as the victim must miss, and every other entry must still hit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // Access kind carried by a lookup request
    typedef enum logic {
        ACC_LOAD  = 1'b0,
        ACC_STORE = 1'b1
    } acc_e;

    // Where a refill lands
    typedef enum logic [1:0] {
        VSRC_MATCH  = 2'd0,
        VSRC_FREE   = 2'd1,
        VSRC_OLDEST = 2'd2
    } vsrc_e;

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
    parameter int N     = 32,
    parameter int VPN_W = 30,
    parameter int PID_W = 8
) (
    input  logic [N-1:0]            ent_valid,
    input  logic [N-1:0][VPN_W-1:0] ent_tag,
    input  logic [N-1:0][PID_W-1:0] ent_pid,
    input  logic [VPN_W-1:0]        key_vpn,
    input  logic [PID_W-1:0]        key_pid,
    output logic [N-1:0]            hit_vec
);

    // One comparator per entry, all evaluated in parallel
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = ent_valid[g]
                          && (ent_tag[g] == key_vpn)
                          && (ent_pid[g] == key_pid);
    end

endmodule

// File: rtl/xlat_first.sv
module xlat_first #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] oldest_idx
);

    localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(N - 1);

    // Each entry has a distinct age; 0 is the most recently used
    typedef struct packed {
        logic [N-1:0][IDX_W-1:0] age;
    } lru_st_t;

    lru_st_t        st_d, st_q;
    logic [N-1:0]   is_oldest;
    logic [IDX_W-1:0] touched_age;

    always_comb begin
        st_d        = st_q;
        touched_age = st_q.age[touch_idx];
        if (touch_en) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    st_d.age[i] = '0;
                end else if (st_q.age[i] < touched_age) begin
                    st_d.age[i] = st_q.age[i] + 1'b1;
                end
            end
        end
        oldest_idx = '0;
        for (int i = 0; i < N; i++) begin
            is_oldest[i] = (st_q.age[i] == AGE_MAX);
            if (is_oldest[i]) begin
                oldest_idx = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                st_q.age[i] <= IDX_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    // R7: the ages stay a permutation, so exactly one entry is oldest
    a_r7_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_oldest) == 1)
        else $error("a_r7_single_oldest");

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer #(
    parameter int N     = 32,
    parameter int VPN_W = 30,
    parameter int OFF_W = 13,
    parameter int PFN_W = 21,
    parameter int PID_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [VPN_W-1:0]       req_vpn,
    input  logic [OFF_W-1:0]       req_off,
    input  logic [PID_W-1:0]       req_pid,
    input  logic                   req_store,
    input  logic                   fill_valid,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [PID_W-1:0]       fill_pid,
    input  logic [PFN_W-1:0]       fill_pfn,
    input  logic                   fill_rd,
    input  logic                   fill_wr,
    input  logic                   flush,
    output logic                   rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_fault,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr
);

    import xlat_pkg::*;

    localparam int IDX_W = $clog2(N);
    localparam int PA_W  = PFN_W + OFF_W;

    typedef struct packed {
        logic [N-1:0]            valid;
        logic [N-1:0][VPN_W-1:0] tag;
        logic [N-1:0][PID_W-1:0] pid;
        logic [N-1:0][PFN_W-1:0] pfn;
        logic [N-1:0]            rd;
        logic [N-1:0]            wr;
        logic                    rsp_valid;
        logic                    rsp_hit;
        logic                    rsp_fault;
        logic [PFN_W-1:0]        rsp_pfn;
        logic [OFF_W-1:0]        rsp_off;
    } tlb_st_t;

    tlb_st_t st_d, st_q;

    logic [N-1:0]     lk_vec, fl_vec;
    logic             lk_any, fl_any, free_any;
    logic [IDX_W-1:0] lk_idx, fl_idx, free_idx, old_idx;
    logic [IDX_W-1:0] victim;
    vsrc_e            vsrc;
    logic [PFN_W-1:0] sel_pfn;
    logic             sel_rd, sel_wr;
    logic             perm_bad;
    logic             touch_en;
    logic [IDX_W-1:0] touch_idx;
    acc_e             acc;

    xlat_cam #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_lk (
        .ent_valid (st_q.valid),
        .ent_tag   (st_q.tag),
        .ent_pid   (st_q.pid),
        .key_vpn   (req_vpn),
        .key_pid   (req_pid),
        .hit_vec   (lk_vec)
    );

    xlat_cam #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_fl (
        .ent_valid (st_q.valid),
        .ent_tag   (st_q.tag),
        .ent_pid   (st_q.pid),
        .key_vpn   (fill_vpn),
        .key_pid   (fill_pid),
        .hit_vec   (fl_vec)
    );

    xlat_first #(.N(N), .IDX_W(IDX_W)) u_enc_lk (
        .vec (lk_vec), .found (lk_any), .idx (lk_idx)
    );

    xlat_first #(.N(N), .IDX_W(IDX_W)) u_enc_fl (
        .vec (fl_vec), .found (fl_any), .idx (fl_idx)
    );

    xlat_first #(.N(N), .IDX_W(IDX_W)) u_enc_free (
        .vec (~st_q.valid), .found (free_any), .idx (free_idx)
    );

    xlat_lru #(.N(N), .IDX_W(IDX_W)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .oldest_idx (old_idx)
    );

    // Frame and permission select: AND-OR over one-hot match lines
    always_comb begin
        sel_pfn = '0;
        sel_rd  = 1'b0;
        sel_wr  = 1'b0;
        for (int i = 0; i < N; i++) begin
            sel_pfn |= st_q.pfn[i] & {PFN_W{lk_vec[i]}};
            sel_rd  |= st_q.rd[i] & lk_vec[i];
            sel_wr  |= st_q.wr[i] & lk_vec[i];
        end
    end

    // Refill placement: existing match, then free slot, then oldest
    always_comb begin
        if (fl_any) begin
            vsrc   = VSRC_MATCH;
            victim = fl_idx;
        end else if (free_any) begin
            vsrc   = VSRC_FREE;
            victim = free_idx;
        end else begin
            vsrc   = VSRC_OLDEST;
            victim = old_idx;
        end
    end

    always_comb begin
        st_d     = st_q;
        acc      = acc_e'(req_store);
        perm_bad = (acc == ACC_STORE) ? !sel_wr : !sel_rd;

        // response stage
        st_d.rsp_valid = req_valid;
        st_d.rsp_hit   = req_valid && lk_any && !flush;
        st_d.rsp_fault = req_valid && lk_any && !flush && perm_bad;
        st_d.rsp_pfn   = (req_valid && lk_any && !flush) ? sel_pfn : '0;
        st_d.rsp_off   = req_valid ? req_off : '0;

        // entry array
        touch_en  = 1'b0;
        touch_idx = lk_idx;
        if (flush) begin
            st_d.valid = '0;
        end else if (fill_valid) begin
            st_d.valid[victim] = 1'b1;
            st_d.tag[victim]   = fill_vpn;
            st_d.pid[victim]   = fill_pid;
            st_d.pfn[victim]   = fill_pfn;
            st_d.rd[victim]    = fill_rd;
            st_d.wr[victim]    = fill_wr;
            touch_en           = 1'b1;
            touch_idx          = victim;
        end else if (req_valid && lk_any) begin
            touch_en  = 1'b1;
            touch_idx = lk_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_fault = st_q.rsp_fault;
    assign rsp_paddr = {st_q.rsp_pfn, st_q.rsp_off};

    // R1: response one cycle after each request, never otherwise
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("a_r1_rsp_follows_req");

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid)
        else $error("a_r1_no_spurious_rsp");

    // R2: at most one entry matches a lookup key
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec))
        else $error("a_r2_single_match");

    // R3: offset passes through, frame zero on a miss
    a_r3_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_paddr[OFF_W-1:0] == $past(req_off))
        else $error("a_r3_offset_passes");

    a_r3_miss_zero_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr[PA_W-1:OFF_W] == '0))
        else $error("a_r3_miss_zero_frame");

    // R4: a fault only accompanies a hit
    a_r4_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_hit)
        else $error("a_r4_fault_needs_hit");

    // R9: flush forces a miss and empties the array
    a_r9_flush_forces_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && req_valid) |=> (rsp_valid && !rsp_hit))
        else $error("a_r9_flush_forces_miss");

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.valid == '0))
        else $error("a_r9_flush_clears");

endmodule

// File: tb/xlat_buffer_tb_top.sv
module xlat_buffer_tb_top;

    localparam int  N          = 32;
    localparam int  VPN_W      = 30;
    localparam int  OFF_W      = 13;
    localparam int  PFN_W      = 21;
    localparam int  PID_W      = 8;
    localparam int  PA_W       = PFN_W + OFF_W;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic [VPN_W-1:0] req_vpn;
    logic [OFF_W-1:0] req_off;
    logic [PID_W-1:0] req_pid;
    logic             req_store;
    logic             fill_valid;
    logic [VPN_W-1:0] fill_vpn;
    logic [PID_W-1:0] fill_pid;
    logic [PFN_W-1:0] fill_pfn;
    logic             fill_rd, fill_wr;
    logic             flush;
    logic             rsp_valid, rsp_hit, rsp_fault;
    logic [PA_W-1:0]  rsp_paddr;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_buffer dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vpn(req_vpn), .req_off(req_off),
        .req_pid(req_pid), .req_store(req_store),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_pfn(fill_pfn), .fill_rd(fill_rd), .fill_wr(fill_wr),
        .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Behavioural reference: flat arrays plus a recency queue
    bit               m_v  [N];
    logic [VPN_W-1:0] m_tag[N];
    logic [PID_W-1:0] m_pid[N];
    logic [PFN_W-1:0] m_pfn[N];
    bit               m_rd [N];
    bit               m_wr [N];
    int               recent_q[$];   // front = most recently used

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void touch(input int k);
        for (int j = 0; j < recent_q.size(); j++) begin
            if (recent_q[j] == k) begin
                recent_q.delete(j);
                break;
            end
        end
        recent_q.push_front(k);
    endfunction

    function automatic int find(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid);
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_tag[i] == vpn && m_pid[i] == pid) return i;
        end
        return -1;
    endfunction

    // One clock: drive, predict, update model, compare at the next falling edge
    task automatic step(input bit rv, input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                        input logic [PID_W-1:0] pid, input bit st,
                        input bit fv, input logic [VPN_W-1:0] fvpn, input logic [PID_W-1:0] fpid,
                        input logic [PFN_W-1:0] fpfn, input bit frd, input bit fwr,
                        input bit fl, input string tag);
        int  hi, vic;
        bit  e_hit, e_fault;
        logic [PA_W-1:0] e_pa;
        req_valid = rv; req_vpn = vpn; req_off = off; req_pid = pid; req_store = st;
        fill_valid = fv; fill_vpn = fvpn; fill_pid = fpid; fill_pfn = fpfn;
        fill_rd = frd; fill_wr = fwr; flush = fl;

        hi      = find(vpn, pid);
        e_hit   = rv && !fl && (hi >= 0);
        e_fault = e_hit && (st ? !m_wr[hi] : !m_rd[hi]);
        e_pa    = rv ? {(e_hit ? m_pfn[hi] : {PFN_W{1'b0}}), off} : '0;

        if (fl) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end else if (fv) begin
            vic = find(fvpn, fpid);
            if (vic < 0) begin
                for (int i = 0; i < N; i++) begin
                    if (!m_v[i]) begin vic = i; break; end
                end
            end
            if (vic < 0) vic = recent_q[$];
            m_v[vic] = 1'b1; m_tag[vic] = fvpn; m_pid[vic] = fpid;
            m_pfn[vic] = fpfn; m_rd[vic] = frd; m_wr[vic] = fwr;
            touch(vic);
        end else if (rv && hi >= 0) begin
            touch(hi);
        end

        @(negedge clk);
        cycles++;
        chk(rsp_valid == rv, tag, "R1 rsp_valid", 64'(rsp_valid), 64'(rv));
        chk(rsp_hit == e_hit, tag, "R2 rsp_hit", 64'(rsp_hit), 64'(e_hit));
        chk(rsp_fault == e_fault, tag, "R4 rsp_fault", 64'(rsp_fault), 64'(e_fault));
        if (rv) chk(rsp_paddr == e_pa, tag, "R3 rsp_paddr", 64'(rsp_paddr), 64'(e_pa));
    endtask

    task automatic look(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                        input bit st, input string tag);
        step(1, vpn, 13'($urandom), pid, st, 0, '0, '0, '0, 0, 0, 0, tag);
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                        input logic [PFN_W-1:0] pfn, input bit rd, input bit wr, input string tag);
        step(0, '0, '0, '0, 0, 1, vpn, pid, pfn, rd, wr, 0, tag);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_tag[i] = '0; m_pid[i] = '0; m_pfn[i] = '0;
            m_rd[i] = 0; m_wr[i] = 0;
            recent_q.push_back(i);
        end
        rst_n = 0;
        req_valid = 0; req_vpn = '0; req_off = '0; req_pid = '0; req_store = 0;
        fill_valid = 0; fill_vpn = '0; fill_pid = '0; fill_pfn = '0;
        fill_rd = 0; fill_wr = 0; flush = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        chk(rsp_valid == 0, "R1", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk(rsp_hit == 0, "R1", "reset rsp_hit", 64'(rsp_hit), 64'd0);

        // R1: empty buffer misses
        look(30'h100, 8'd1, 0, "R1");
        step(0, '0, '0, '0, 0, 0, '0, '0, '0, 0, 0, 0, "R1");

        // R2 R3 R4: basic hits, pid separation, permissions
        fill(30'h100, 8'd1, 21'h0ABCD, 1, 1, "R6");
        fill(30'h200, 8'd1, 21'h12345, 1, 0, "R6");
        fill(30'h300, 8'd1, 21'h1FFFF, 0, 1, "R6");
        look(30'h100, 8'd1, 0, "R2");
        look(30'h100, 8'd1, 1, "R3");
        look(30'h100, 8'd2, 0, "R2");
        look(30'h200, 8'd1, 1, "R4");
        look(30'h200, 8'd1, 0, "R4");
        look(30'h300, 8'd1, 0, "R4");
        look(30'h300, 8'd1, 1, "R4");

        // R5: refill of an existing translation overwrites it
        fill(30'h200, 8'd1, 21'h00777, 1, 1, "R5");
        look(30'h200, 8'd1, 1, "R5");

        // R10: fill the remaining entries and hit every one
        for (int i = 3; i < N; i++) fill(30'(32'h1000 + i), 8'd3, 21'(i * 5 + 1), 1, 1, "R10");
        for (int i = 3; i < N; i++) look(30'(32'h1000 + i), 8'd3, 0, "R10");
        look(30'h100, 8'd1, 0, "R10");

        // R7: refresh a few entries, then force evictions
        look(30'h200, 8'd1, 0, "R7");
        look(30'h300, 8'd1, 0, "R7");
        fill(30'h5000, 8'd4, 21'h00ABC, 1, 1, "R7");
        fill(30'h5001, 8'd4, 21'h00ABD, 1, 1, "R7");
        for (int i = 3; i < 8; i++) look(30'(32'h1000 + i), 8'd3, 0, "R7");
        look(30'h100, 8'd1, 0, "R7");
        look(30'h200, 8'd1, 0, "R7");
        look(30'h5000, 8'd4, 0, "R7");

        // R8: lookup alongside a refill of the same page sees the old state
        step(1, 30'h6000, 13'h1F0, 8'd5, 0, 1, 30'h6000, 8'd5, 21'h0F0F0, 1, 1, 0, "R8");
        look(30'h6000, 8'd5, 0, "R8");
        step(1, 30'h1009, 13'h004, 8'd3, 0, 1, 30'h6100, 8'd5, 21'h0F0F1, 1, 1, 0, "R8");
        fill(30'h6200, 8'd5, 21'h0F0F2, 1, 1, "R8");
        look(30'h1009, 8'd3, 0, "R8");

        // R9: flush with lookup and refill in the same cycle
        step(1, 30'h6000, 13'h0AA, 8'd5, 0, 1, 30'h7000, 8'd6, 21'h1, 1, 1, 1, "R9");
        look(30'h6000, 8'd5, 0, "R9");
        look(30'h7000, 8'd6, 0, "R9");
        look(30'h100, 8'd1, 0, "R9");
        fill(30'h7000, 8'd6, 21'h2, 1, 1, "R6");
        look(30'h7000, 8'd6, 1, "R6");

        // Mixed traffic over a small page space to stress replacement
        for (int c = 0; c < 4000; c++) begin
            int r;
            bit rv, fv, fl;
            r  = $urandom_range(0, 99);
            rv = (r < 70);
            fv = ($urandom_range(0, 99) < 25);
            fl = ($urandom_range(0, 999) < 5);
            step(rv, 30'($urandom_range(0, 47)), 13'($urandom), 8'($urandom_range(0, 1)),
                 1'($urandom), fv, 30'($urandom_range(0, 47)), 8'($urandom_range(0, 1)),
                 21'($urandom), 1'($urandom), 1'($urandom), fl, "R7");
        end

        step(0, '0, '0, '0, 0, 0, '0, '0, '0, 0, 0, 0, "R1");
        finish_run();
    end

endmodule